// File: doc/BRIEF.md
# Single-Bit Set/Clear Execution Unit

This unit executes the second byte of a two-byte prefixed instruction when that byte asks for one bit of a register to be forced to 1 or to 0. It sits beside an eight-entry file of 8-bit registers. It drives the read index of that file from the opcode. It applies a one-hot mask to the value it reads back, and it returns the result through a write port with a one-cycle enable. The same cycle it reports how many machine cycles the instruction costs, or it flags the opcode as one it does not execute.

A caller presents the opcode with a one-cycle strobe. The file is read combinationally in the strobe cycle. In the following cycle the unit holds the write-back index, data and enable, the result strobe and either the cycle count or the unsupported flag. Strobes may arrive on consecutive cycles. If a strobe targets the register whose write is still in flight, the unit uses the pending write data in place of the stale file contents. Index 6 is an ordinary register here, not a memory operand.

Top module: `bitop_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied and in the first cycle after it, `wr_en`, `res_vld`, `unsup` are 0 and `cycles` is 0.
- R2: An opcode from 0xC0 to 0xFF is a set: bits [5:3] give the bit position and bits [2:0] the register. The written value is the read value with that bit forced to 1 and all other bits kept.
- R3: An opcode from 0x80 to 0xBF is a clear with the same field positions. The written value is the read value with that bit forced to 0 and all other bits kept.
- R4: During a strobe, `rd_idx` equals opcode bits [2:0]. The write-back `wr_idx` of a supported opcode equals that same field.
- R5: The write-back appears in the cycle after the strobe, and `wr_en` is high for exactly one cycle per supported strobe.
- R6: A supported opcode returns `res_vld`=1, `unsup`=0 and `cycles`=OP_CYCLES (8 by default) in the cycle after the strobe.
- R7: An opcode from 0x00 to 0x7F returns `res_vld`=1, `unsup`=1 and `cycles`=0, and it asserts no `wr_en`, so no register changes.
- R8: Register index 6 is read and written like every other index.
- R9: When a strobe follows another on the next cycle and targets the same register, it operates on the first result, so both bit changes reach the register.
- R10: In a cycle after one without a strobe, `res_vld`, `wr_en` and `unsup` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Opcode strobe, one cycle per instruction |
| op_byte | input | 8 | Prefixed opcode byte |
| rd_idx | output | 3 | Register file read index |
| rd_data | input | 8 | Register file read data (combinational) |
| wr_en | output | 1 | Register write enable, one-cycle pulse |
| wr_idx | output | 3 | Register write index |
| wr_data | output | 8 | Register write data |
| res_vld | output | 1 | Result strobe for every accepted opcode |
| cycles | output | CYC_W | Cycle cost of the executed opcode |
| unsup | output | 1 | Opcode not executed by this unit |

## Verification
The bench builds the unit with its defaults, OP_CYCLES=8 and CYC_W=8. With these the cycle count can be compared against the literal 8, and the full opcode byte is decoded, so every set and clear group edge (0x80, 0xBF, 0xC0, 0xFF) and the unsupported range below 0x80 can be reached. The bench models the register file itself. Pre-loaded values in which the target bit is already in the requested state show that no other bit is disturbed. Same-register strobes on consecutive cycles exercise the forwarding path.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int OP_CYCLES = 8,
  parameter int CYC_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [7:0]       op_byte,
  output logic [2:0]       rd_idx,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [2:0]       wr_idx,
  output logic [7:0]       wr_data,
  output logic             res_vld,
  output logic [CYC_W-1:0] cycles,
  output logic             unsup
);

  logic [2:0] bit_sel;
  logic [2:0] reg_sel;
  logic       is_set;
  logic       is_ok;
  logic       fwd;
  logic [7:0] src;
  logic [7:0] mask;
  logic [7:0] result;

  assign bit_sel = op_byte[5:3];
  assign reg_sel = op_byte[2:0];
  assign is_ok   = op_byte[7];
  assign is_set  = op_byte[6];
  assign rd_idx  = reg_sel;
  assign fwd     = wr_en && (wr_idx == reg_sel);
  assign src     = fwd ? wr_data : rd_data;
  assign mask    = 8'd1 << bit_sel;
  assign result  = is_set ? (src | mask) : (src & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      res_vld <= 1'b0;
      cycles  <= '0;
      unsup   <= 1'b0;
    end else begin
      wr_en   <= op_vld && is_ok;
      res_vld <= op_vld;
      unsup   <= op_vld && !is_ok;
      cycles  <= (op_vld && is_ok) ? CYC_W'(OP_CYCLES) : '0;
      if (op_vld && is_ok) begin
        wr_idx  <= reg_sel;
        wr_data <= result;
      end
    end
  end

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int OP_CYCLES = 8,
  parameter int CYC_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_vld,
  input logic [7:0]       op_byte,
  input logic             wr_en,
  input logic [2:0]       wr_idx,
  input logic [7:0]       wr_data,
  input logic             res_vld,
  input logic [CYC_W-1:0] cycles,
  input logic             unsup
);

  a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_byte[7:6] == 2'b11 |=> wr_en && wr_data[$past(op_byte[5:3])]);

  a_r3_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_byte[7:6] == 2'b10 |=> wr_en && !wr_data[$past(op_byte[5:3])]);

  a_r4_wr_index: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_byte[7] |=> wr_idx == $past(op_byte[2:0]));

  a_r5_wr_origin: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(op_vld) && $past(op_byte[7]));

  a_r6_cycle_cost: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_byte[7] |=> res_vld && !unsup && cycles == CYC_W'(OP_CYCLES));

  a_r7_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && !op_byte[7] |=> res_vld && unsup && !wr_en && cycles == '0);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> !res_vld && !wr_en && !unsup);

endmodule

bind bitop_unit bitop_unit_chk #(.OP_CYCLES(OP_CYCLES), .CYC_W(CYC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_byte(op_byte),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .res_vld(res_vld), .cycles(cycles), .unsup(unsup)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_vld = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic [2:0] rd_idx;
  logic [7:0] rd_data;
  logic       wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic       res_vld;
  logic [7:0] cycles;
  logic       unsup;
  logic [7:0] regs [8];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign rd_data = regs[rd_idx];
  always @(posedge clk) if (wr_en) regs[wr_idx] <= wr_data;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_byte(op_byte),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .res_vld(res_vld), .cycles(cycles), .unsup(unsup)
  );

  // {opcode, preload, expected}
  localparam logic [23:0] VEC [10] = '{
    {8'hC0, 8'h00, 8'h01}, {8'hFF, 8'h00, 8'h80}, {8'hF6, 8'h0F, 8'h4F},
    {8'hDB, 8'hFF, 8'hFF}, {8'h80, 8'hFF, 8'hFE}, {8'hBF, 8'hFF, 8'h7F},
    {8'hAE, 8'hA5, 8'h85}, {8'h91, 8'h00, 8'h00}, {8'hE9, 8'h12, 8'h32},
    {8'hA2, 8'h3C, 8'h2C}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_all(input logic [7:0] base);
    for (int i = 0; i < 8; i++) regs[i] = base + 8'(i);
  endtask

  initial begin
    load_all(8'h10);
    repeat (3) @(negedge clk);
    chk("R1 wr_en in reset", int'(wr_en), 0);
    chk("R1 res_vld in reset", int'(res_vld), 0);
    chk("R1 unsup/cycles in reset", int'({unsup, cycles}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", int'({wr_en, res_vld, unsup, cycles}), 0);

    for (int v = 0; v < 10; v++) begin
      logic [7:0] op;
      logic [7:0] pre;
      logic [7:0] exp;
      {op, pre, exp} = VEC[v];
      regs[op[2:0]] = pre;
      op_byte = op;
      op_vld = 1'b1;
      #1;
      chk("R4 rd_idx", int'(rd_idx), int'(op[2:0]));
      @(negedge clk);
      op_vld = 1'b0;
      chk(op[6] ? "R2 set wr_data" : "R3 clr wr_data", int'(wr_data), int'(exp));
      chk("R4 wr_idx", int'(wr_idx), int'(op[2:0]));
      chk("R5 wr_en", int'(wr_en), 1);
      chk("R6 res/unsup/cycles", int'({res_vld, unsup, cycles}), int'({1'b1, 1'b0, 8'd8}));
      @(negedge clk);
      chk("R5 single pulse", int'(wr_en), 0);
      chk(op[2:0] == 3'd6 ? "R8 reg6 stored" : "R2/R3 stored", int'(regs[op[2:0]]), int'(exp));
    end

    foreach (VEC[k]) begin end
    for (int u = 0; u < 3; u++) begin
      logic [7:0] op;
      op = (u == 0) ? 8'h00 : (u == 1) ? 8'h46 : 8'h7F;
      load_all(8'h5A);
      op_byte = op;
      op_vld = 1'b1;
      @(negedge clk);
      op_vld = 1'b0;
      chk("R7 unsup flags", int'({res_vld, unsup, wr_en, cycles}), int'({1'b1, 1'b1, 1'b0, 8'd0}));
      @(negedge clk);
      for (int i = 0; i < 8; i++) chk("R7 regs untouched", int'(regs[i]), int'(8'h5A + 8'(i)));
    end

    regs[1] = 8'h00;
    op_byte = 8'hC9;
    op_vld = 1'b1;
    @(negedge clk);
    op_byte = 8'hC1;
    @(negedge clk);
    op_byte = 8'h89;
    chk("R9 second write forwarded", int'(wr_data), 8'h03);
    @(negedge clk);
    op_vld = 1'b0;
    chk("R9 third write forwarded", int'(wr_data), 8'h01);
    @(negedge clk);
    chk("R9 final register", int'(regs[1]), 8'h01);

    repeat (3) begin
      @(negedge clk);
      chk("R10 idle quiet", int'({res_vld, wr_en, unsup}), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule